// File: doc/BRIEF.md
# Operand Forwarding Control for a Five-Stage Pipeline

This block steers operand values into the execute stage of an in-order five-stage pipeline. Each cycle it compares the two source register numbers of the instruction now in execute with the destinations held in the two pipeline registers downstream. It then selects, for each ALU operand, either the register-file value or a newer result that has not yet been written back. The design includes those two pipeline registers, the operand muxes and a small ALU, so the selects and the values they choose can both be seen at the ports.

A store that directly follows a load of its own data register cannot take that data in execute, because the loaded word does not exist yet. In that case the store carries the stale register value into the memory stage. There a third select swaps in the word the load has just read, while that word sits in the writeback register. The block depends on a register file that writes in the first half of a cycle and reads in the second, so a producer three instructions ahead needs no path. Stalls, branches and caches belong to the surrounding pipeline.

Top module: `operand_bypass_core`

## Requirements
- R1: When the instruction one ahead (in the execute/memory register) has write enable 1, is not a load, has a nonzero destination, and that destination equals a source, that operand's select is 2'b10 and the operand equals that instruction's ALU result.
- R2: When R1 does not apply to a source and the instruction two ahead (in the memory/writeback register) has write enable 1, a nonzero destination equal to the source, the select is 2'b01 and the operand equals its writeback value (loaded word for a load, ALU result otherwise).
- R3: When both downstream instructions match the same source under R1 and R2, the select is 2'b10: the nearer instruction takes priority.
- R4: A producer three or more instructions ahead causes no forwarding. The select is 2'b00 and the operand is the register-file input.
- R5: Register 0 is never forwarded, and a downstream instruction with write enable 0 is never forwarded. In both cases the select is 2'b00.
- R6: A load one ahead never produces select 2'b10, because its ALU result is an address and not data.
- R7: When the memory stage holds a store and the writeback register holds a load with a nonzero destination equal to the store's data register, fwd_c is 1 and mem_wdata is the loaded word. Otherwise fwd_c is 0 and mem_wdata is the forwarded data-register value the store carried from execute.
- R8: ex_op selects 00 add, 01 subtract (A minus B), 10 AND, 11 OR. When ex_imm_en is 1, operand B is ex_imm. Loads and stores use add with the immediate, so the address is base plus offset.
- R9: In the memory stage, mem_we is 1 for a store and mem_re is 1 for a load, and mem_addr is the ALU result. Two cycles after an instruction enters execute, wb_we, wb_dst and wb_value show its write enable, destination and result.
- R10: While reset is asserted and right after it, wb_we, mem_we, mem_re and fwd_c are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of pipeline control |
| ex_src_a | input | RW | Source register A of the instruction in execute |
| ex_src_b | input | RW | Source register B (store data register for stores) |
| ex_dst | input | RW | Destination register |
| ex_we | input | 1 | Register write enable |
| ex_load | input | 1 | Instruction is a load |
| ex_store | input | 1 | Instruction is a store |
| ex_op | input | 2 | ALU operation code |
| ex_imm_en | input | 1 | Operand B comes from the immediate |
| ex_imm | input | XLEN | Immediate value |
| ex_rf_a | input | XLEN | Register-file value read for source A |
| ex_rf_b | input | XLEN | Register-file value read for source B |
| mem_rdata | input | XLEN | Data-memory read word for the load in memory stage |
| fwd_a | output | 2 | Operand A select |
| fwd_b | output | 2 | Operand B / store data select |
| fwd_c | output | 1 | Store data from writeback load word |
| mem_addr | output | XLEN | Data-memory address |
| mem_wdata | output | XLEN | Data-memory write data |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe |
| wb_we | output | 1 | Register write enable at writeback |
| wb_dst | output | RW | Register written at writeback |
| wb_value | output | XLEN | Value written at writeback |

## Verification
The hardest state to reach is a load directly followed by a store of the same register, with an older writer of that register also two ahead. In that state the data select picks the writeback value in execute and the memory-stage swap must then override it. Random programs draw from only eight registers and issue loads and stores often, so this state and same-register chains at distance one, two and three come up many times. Directed sequences add the classic subtract-then-consumers chain, writes to register 0 and the both-stages-match priority case. The bench models the register file as write-before-read and keeps the ALU clear of load-use pairs, which belong to a stall unit.

// File: rtl/operand_bypass_core.sv
module operand_bypass_core #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   ex_src_a,
  input  logic [RW-1:0]   ex_src_b,
  input  logic [RW-1:0]   ex_dst,
  input  logic            ex_we,
  input  logic            ex_load,
  input  logic            ex_store,
  input  logic [1:0]      ex_op,
  input  logic            ex_imm_en,
  input  logic [XLEN-1:0] ex_imm,
  input  logic [XLEN-1:0] ex_rf_a,
  input  logic [XLEN-1:0] ex_rf_b,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b,
  output logic            fwd_c,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic            wb_we,
  output logic [RW-1:0]   wb_dst,
  output logic [XLEN-1:0] wb_value
);
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_WB = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic [XLEN-1:0] m_alu, m_sdata;
  logic [RW-1:0]   m_dst, m_sb;
  logic            m_we, m_ld, m_st;
  logic [XLEN-1:0] w_alu, w_ldata;
  logic [RW-1:0]   w_dst;
  logic            w_we, w_ld;

  logic m_live, w_live;
  logic hit_ma, hit_mb, hit_wa, hit_wb;
  logic [XLEN-1:0] opa, opb_reg, opb, alu_y;

  assign m_live = m_we & ~m_ld & (|m_dst);
  assign w_live = w_we & (|w_dst);
  assign hit_ma = m_live & (m_dst == ex_src_a);
  assign hit_mb = m_live & (m_dst == ex_src_b);
  assign hit_wa = w_live & (w_dst == ex_src_a);
  assign hit_wb = w_live & (w_dst == ex_src_b);

  assign fwd_a = hit_ma ? SEL_MEM : (hit_wa ? SEL_WB : SEL_RF);
  assign fwd_b = hit_mb ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);

  assign wb_value = w_ld ? w_ldata : w_alu;

  always_comb begin
    case (fwd_a)
      SEL_MEM: opa = m_alu;
      SEL_WB:  opa = wb_value;
      default: opa = ex_rf_a;
    endcase
    case (fwd_b)
      SEL_MEM: opb_reg = m_alu;
      SEL_WB:  opb_reg = wb_value;
      default: opb_reg = ex_rf_b;
    endcase
  end

  assign opb = ex_imm_en ? ex_imm : opb_reg;

  always_comb begin
    case (ex_op)
      2'b00:   alu_y = opa + opb;
      2'b01:   alu_y = opa - opb;
      2'b10:   alu_y = opa & opb;
      default: alu_y = opa | opb;
    endcase
  end

  assign fwd_c     = m_st & w_ld & w_live & (w_dst == m_sb);
  assign mem_wdata = fwd_c ? w_ldata : m_sdata;
  assign mem_addr  = m_alu;
  assign mem_we    = m_st;
  assign mem_re    = m_ld;
  assign wb_we     = w_we;
  assign wb_dst    = w_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_we <= 1'b0;
      m_ld <= 1'b0;
      m_st <= 1'b0;
      w_we <= 1'b0;
      w_ld <= 1'b0;
    end else begin
      m_we <= ex_we;
      m_ld <= ex_load;
      m_st <= ex_store;
      w_we <= m_we;
      w_ld <= m_ld;
    end
    m_dst   <= ex_dst;
    m_sb    <= ex_src_b;
    m_alu   <= alu_y;
    m_sdata <= opb_reg;
    w_dst   <= m_dst;
    w_alu   <= m_alu;
    w_ldata <= mem_rdata;
  end

  // R1
  near_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b10) |-> (opa == mem_addr));
  // R2
  far_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b01) |-> (opa == wb_value));
  // R3
  near_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_we && !m_ld && m_dst != '0 && m_dst == ex_src_b) |-> (fwd_b == 2'b10));
  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_a == '0) |-> (fwd_a == 2'b00));
  // R6
  load_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (fwd_a != 2'b10 && fwd_b != 2'b10));
  // R7
  store_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_c |-> (mem_we && mem_wdata == w_ldata));
  // R9
  wb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> $past(m_we));
endmodule

// File: tb/test_operand_bypass_core.sv
`timescale 1ns/1ps
module test_operand_bypass_core;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RW = 5;
  localparam int N = 340;
  localparam int NRAND = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] ex_src_a, ex_src_b, ex_dst;
  logic ex_we, ex_load, ex_store, ex_imm_en;
  logic [1:0] ex_op;
  logic [XLEN-1:0] ex_imm, ex_rf_a, ex_rf_b, mem_rdata;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_c, mem_we, mem_re, wb_we;
  logic [XLEN-1:0] mem_addr, mem_wdata, wb_value;
  logic [RW-1:0] wb_dst;

  operand_bypass_core #(.XLEN(XLEN), .NREG(NREG)) i_operand_bypass_core (
    .clk(clk), .rst_n(rst_n), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_dst(ex_dst), .ex_we(ex_we), .ex_load(ex_load), .ex_store(ex_store),
    .ex_op(ex_op), .ex_imm_en(ex_imm_en), .ex_imm(ex_imm), .ex_rf_a(ex_rf_a),
    .ex_rf_b(ex_rf_b), .mem_rdata(mem_rdata), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .fwd_c(fwd_c), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .wb_we(wb_we), .wb_dst(wb_dst), .wb_value(wb_value));

  always #10 clk = ~clk;

  logic [XLEN-1:0] dmem [16];
  assign mem_rdata = dmem[mem_addr[5:2]];
  always_ff @(posedge clk) if (rst_n && mem_we) dmem[mem_addr[5:2]] <= mem_wdata;

  logic [RW-1:0] p_sa [N], p_sb [N], p_dst [N];
  logic p_we [N], p_ld [N], p_st [N], p_ie [N];
  logic [1:0] p_op [N];
  logic [XLEN-1:0] p_imm [N], g_val [N], g_sd [N], g_addr [N];
  int np = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic add_i(input int sa, input int sb, input int d, input bit we,
                       input bit ld, input bit st, input int op, input bit ie, input int imm);
    p_sa[np] = RW'(sa); p_sb[np] = RW'(sb); p_dst[np] = RW'(d);
    p_we[np] = we; p_ld[np] = ld; p_st[np] = st; p_op[np] = 2'(op);
    p_ie[np] = ie; p_imm[np] = XLEN'(imm);
    np++;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input int k, input logic [RW-1:0] s);
    if (k >= 1 && p_we[k-1] && !p_ld[k-1] && p_dst[k-1] != 0 && p_dst[k-1] == s) return 2'b10;
    if (k >= 2 && p_we[k-2] && p_dst[k-2] != 0 && p_dst[k-2] == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] alu_ref(input logic [1:0] op, input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
    case (op)
      2'b00: return a + b;
      2'b01: return a - b;
      2'b10: return a & b;
      default: return a | b;
    endcase
  endfunction

  initial begin
    logic [XLEN-1:0] gold [NREG];
    logic [XLEN-1:0] gmem [16];
    logic [XLEN-1:0] rfm [NREG];
    void'($urandom(32'd2024));
    for (int r = 0; r < NREG; r++) begin
      gold[r] = (r == 0) ? '0 : XLEN'(r * 32'h0101_0101 + 32'h35);
      rfm[r] = gold[r];
    end
    for (int m = 0; m < 16; m++) begin
      gmem[m] = XLEN'(32'hA000_0000 + m * 32'h111);
      dmem[m] = gmem[m];
    end
    // dependence chain: sub r2,r1,r3 ; and r12,r2,r5 ; or r13,r6,r2 ; add r14,r2,r2 ; sw r15,100(r2)
    add_i(1, 3, 2, 1, 0, 0, 1, 0, 0);
    add_i(2, 5, 12, 1, 0, 0, 2, 0, 0);
    add_i(6, 2, 13, 1, 0, 0, 3, 0, 0);
    add_i(2, 2, 14, 1, 0, 0, 0, 0, 0);
    add_i(2, 15, 0, 0, 0, 1, 0, 1, 100);
    // load then store of the same register
    add_i(2, 0, 1, 1, 1, 0, 0, 1, 8);
    add_i(4, 1, 0, 0, 0, 1, 0, 1, 12);
    // writes to register 0 must not forward
    add_i(3, 4, 0, 1, 0, 0, 0, 0, 0);
    add_i(0, 0, 7, 1, 0, 0, 3, 0, 0);
    // both stages hold r5
    add_i(1, 1, 5, 1, 0, 0, 0, 0, 0);
    add_i(3, 3, 5, 1, 0, 0, 0, 0, 0);
    add_i(5, 5, 9, 1, 0, 0, 1, 0, 0);
    // disabled writer with matching destination
    add_i(1, 2, 6, 0, 0, 0, 0, 0, 0);
    add_i(6, 6, 8, 1, 0, 0, 2, 0, 0);
    for (int i = 0; i < NRAND; i++) begin
      int kind = $urandom % 8;
      int sa = $urandom % 8, sb = $urandom % 8, d = $urandom % 8;
      int imm = ($urandom % 16) * 4;
      bit prevld = p_ld[np-1];
      int pd = p_dst[np-1];
      if (prevld && sa == pd) sa = sa ^ 1;
      if (kind < 2) add_i(sa, sb, d, 1, 1, 0, 0, 1, imm);
      else if (kind == 2) add_i(sa, sb, 0, 0, 0, 1, 0, 1, imm);
      else begin
        bit ie = ($urandom % 4) == 0;
        if (prevld && !ie && sb == pd) sb = sb ^ 1;
        add_i(sa, sb, d, ($urandom % 8) != 0, 0, 0, $urandom % 4, ie, imm);
      end
    end
    for (int i = 0; i < 3; i++) add_i(0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < np; k++) begin
      logic [XLEN-1:0] a, b;
      a = gold[p_sa[k]];
      b = p_ie[k] ? p_imm[k] : gold[p_sb[k]];
      g_addr[k] = alu_ref(p_op[k], a, b);
      g_sd[k] = gold[p_sb[k]];
      g_val[k] = p_ld[k] ? gmem[g_addr[k][5:2]] : g_addr[k];
      if (p_st[k]) gmem[g_addr[k][5:2]] = g_sd[k];
      if (p_we[k] && p_dst[k] != 0) gold[p_dst[k]] = g_val[k];
    end

    ex_src_a = '0; ex_src_b = '0; ex_dst = '0; ex_we = 0; ex_load = 0; ex_store = 0;
    ex_op = '0; ex_imm_en = 0; ex_imm = '0; ex_rf_a = '0; ex_rf_b = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(wb_we == 0 && mem_we == 0 && mem_re == 0 && fwd_c == 0, "R10", "reset strobes",
        {wb_we, mem_we, mem_re, fwd_c}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(wb_we == 0 && mem_we == 0 && fwd_c == 0, "R10", "after reset", {wb_we, mem_we, fwd_c}, 0);

    for (int k = 0; k < np + 2; k++) begin
      @(negedge clk);
      if (k >= 3 && k - 3 < np && p_we[k-3] && p_dst[k-3] != 0) rfm[p_dst[k-3]] = g_val[k-3];
      if (k < np) begin
        ex_src_a = p_sa[k]; ex_src_b = p_sb[k]; ex_dst = p_dst[k]; ex_we = p_we[k];
        ex_load = p_ld[k]; ex_store = p_st[k]; ex_op = p_op[k]; ex_imm_en = p_ie[k];
        ex_imm = p_imm[k]; ex_rf_a = rfm[p_sa[k]]; ex_rf_b = rfm[p_sb[k]];
      end else begin
        ex_we = 0; ex_load = 0; ex_store = 0; ex_src_a = '0; ex_src_b = '0; ex_dst = '0;
      end
      #1;
      if (k < np) begin
        // R1 R2 R3 R4 R5 R6 selects
        chk(fwd_a == exp_sel(k, p_sa[k]), "R1/R2/R3/R4", "fwd_a", 32'(fwd_a), 32'(exp_sel(k, p_sa[k])));
        chk(fwd_b == exp_sel(k, p_sb[k]), "R5/R6", "fwd_b", 32'(fwd_b), 32'(exp_sel(k, p_sb[k])));
      end
      if (k >= 1 && k - 1 < np) begin
        logic ec;
        ec = p_st[k-1] && k >= 2 && p_ld[k-2] && p_we[k-2] && p_dst[k-2] != 0 && p_dst[k-2] == p_sb[k-1];
        chk(fwd_c == ec, "R7", "fwd_c", 32'(fwd_c), 32'(ec));
        chk(mem_we == p_st[k-1] && mem_re == p_ld[k-1], "R9", "mem strobes",
            {mem_we, mem_re}, {p_st[k-1], p_ld[k-1]});
        if (p_st[k-1]) begin
          chk(mem_wdata == g_sd[k-1], "R7", "store data", mem_wdata, g_sd[k-1]);
          chk(mem_addr == g_addr[k-1], "R8", "store address", mem_addr, g_addr[k-1]);
        end
      end
      if (k >= 2 && k - 2 < np) begin
        chk(wb_we == p_we[k-2], "R9", "wb_we", 32'(wb_we), 32'(p_we[k-2]));
        if (p_we[k-2] && p_dst[k-2] != 0) begin
          chk(wb_dst == p_dst[k-2], "R9", "wb_dst", 32'(wb_dst), 32'(p_dst[k-2]));
          chk(wb_value == g_val[k-2], "R8", "wb_value", wb_value, g_val[k-2]);
        end
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule